// File: doc/BRIEF.md
# Page Table Entry Cache

This block sits between a translation table walker and the memory system. The walker asks for one 32-bit table word by physical address. The cache keeps recently used 16-byte atoms so that repeated walks over the same directory or table region are answered without a memory trip. On a miss, or whenever the cache is turned off, the block fetches the whole atom through a memory read port and returns the requested word from it.

Software-side control arrives as three register writes:

- **Configuration.** A write sets the enable bit, a cap on how many fetches may be in flight, and a six-bit mask that shapes how atom addresses fold onto the eight lines.
- **Flush.** A write either empties the whole cache or removes the one atom that holds a given address.
- **Flush high bits.** A separate write supplies the physical address bits above 31 for a flush by address.

Responses always come back in the order the requests were accepted.

Top module: `pte_cache`

## Requirements
- R1: After reset, and until the first configuration write, the configuration is: enable clear, fetch limit 8, index mask 0x3f. No line is valid, `req_ready_o` is high and `resp_valid_o` is low.
- R2: While enable (configuration bit 29) is clear, every accepted request causes one memory fetch and returns the addressed word of the fetched atom. The atom is not installed.
- R3: With enable set, a miss issues one fetch at `{req_addr_i[33:4], 4'b0}`. The cycle after `mem_rsp_valid_i` is seen, `resp_valid_o` pulses carrying 32-bit word `req_addr_i[3:2]` of the atom; word k occupies bits `[32k+31:32k]`. The atom is then installed.
- R4: A request that hits while no fetch is outstanding is accepted, issues no fetch, and returns its word in the cycle after acceptance.
- R5: Responses leave in acceptance order. A hit presented while any fetch is outstanding holds `req_ready_o` low until all outstanding fetches have returned.
- R6: Configuration bits [27:24] set the fetch limit. While the outstanding count is at or above the limit, a miss sees `req_ready_o` and `mem_req_valid_o` low. A limit of 0 allows 16 outstanding fetches.
- R7: Configuration bits [5:0] hold mask m. For atom address a = `req_addr_i[33:4]`, the line index bit i is `(a[i] & m[i]) ^ (a[i+3] & m[i+3])` for i in 0..2. Each line holds one atom, and a fill replaces whatever that line held.
- R8: A flush write with bit 0 = 0 invalidates every line.
- R9: A flush write with bit 0 = 1 invalidates only the atom `{high bits, flush_wdata_i[31:4]}`. Flush bits [3:1] are ignored and other lines are kept.
- R10: The flush high register keeps only bits [1:0] of the value written to it. It holds that value until it is rewritten, and a flush issued in the same cycle as a high-register write uses the previous value.
- R11: A flush that covers an atom whose fetch is still outstanding stops that fill from being installed. The pending request still receives its correct response.
- R12: Configuration writes act from the next cycle. Clearing enable does not drop lines, so setting it again makes them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration value (bit 29 enable, [27:24] limit, [5:0] index mask) |
| flush_hi_we_i | input | 1 | Flush high-address write strobe |
| flush_hi_wdata_i | input | 32 | Flush high-address value, bits [1:0] kept |
| flush_we_i | input | 1 | Flush command strobe |
| flush_wdata_i | input | 32 | Bit 0 selects by-address flush; [31:4] low atom address |
| req_valid_i | input | 1 | Table word request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_addr_i | input | 34 | Physical address of the table word |
| resp_valid_o | output | 1 | Response pulse |
| resp_data_o | output | 32 | Returned table word |
| mem_req_valid_o | output | 1 | Atom fetch request |
| mem_req_ready_i | input | 1 | Memory accepts the fetch |
| mem_req_addr_o | output | 34 | Atom-aligned fetch address |
| mem_rsp_valid_i | input | 1 | Fetched atom returns, in fetch order |
| mem_rsp_data_i | input | 128 | Fetched atom data |

## Verification
The hardest case to reach from the ports is a flush that arrives while fills are still in flight. Reaching it needs fetches held in memory, the flush landing in that window, and then a later lookup that proves the late fill was never installed. The bench holds back the memory model's responses at chosen points, so that fetches pile up to the limit and a flush can land among them. It then releases the model and probes the same atoms again, counting fetches. A seeded random phase mixes requests with both flush kinds over a small, conflict-prone address range, and compares the fetch count with a line model built from the index rule.

// File: rtl/pte_cache_pkg.sv
package pte_cache_pkg;
  localparam int CFG_EN_BIT  = 29;
  localparam int CFG_LIM_LSB = 24;
  localparam int LIM_W       = 4;
  localparam int MAP_W       = 6;
  localparam int WORD_W      = 32;

  typedef struct packed {
    logic             en;
    logic [LIM_W-1:0] limit;
    logic [MAP_W-1:0] map;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{en: 1'b0, limit: 4'd8, map: 6'h3f};

  typedef enum logic {
    FL_ALL  = 1'b0,
    FL_ADDR = 1'b1
  } flush_kind_e;
endpackage

// File: rtl/pte_cache_index.sv
module pte_cache_index
  import pte_cache_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [2*IDX_W-1:0] bits_i,
  input  logic [MAP_W-1:0]   map_i,
  output logic [IDX_W-1:0]   idx_o
);
  // fold two masked slices of the atom address
  for (genvar i = 0; i < IDX_W; i++) begin : g_bit
    assign idx_o[i] = (bits_i[i] & map_i[i % MAP_W]) ^
                      (bits_i[i+IDX_W] & map_i[(i+IDX_W) % MAP_W]);
  end
endmodule

// File: rtl/pte_cache_store.sv
module pte_cache_store #(
  parameter int LINES  = 8,
  parameter int ATOM_W = 30,
  parameter int DATA_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [ATOM_W-1:0] rd_atom_i,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ATOM_W-1:0] wr_atom_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inv_all_i,
  input  logic              inv_one_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  input  logic [ATOM_W-1:0] inv_atom_i
);
  logic [LINES-1:0]  valid_a;
  logic [ATOM_W-1:0] tag_a  [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic              vld_q;
    logic [ATOM_W-1:0] tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              wr_sel, inv_sel;

    assign wr_sel  = wr_en_i && (wr_idx_i == IDX_W'(l));
    assign inv_sel = inv_all_i ||
                     (inv_one_i && (inv_idx_i == IDX_W'(l)) && (tag_q == inv_atom_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       vld_q <= 1'b0;
      else if (wr_sel)   vld_q <= 1'b1;
      else if (inv_sel)  vld_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (wr_sel) begin
        tag_q <= wr_atom_i;
        dat_q <= wr_data_i;
      end
    end

    assign valid_a[l] = vld_q;
    assign tag_a[l]   = tag_q;
    assign data_a[l]  = dat_q;
  end

  assign rd_hit_o  = valid_a[rd_idx_i] && (tag_a[rd_idx_i] == rd_atom_i);
  assign rd_data_o = data_a[rd_idx_i];
endmodule

// File: rtl/pte_cache_fifo.sv
module pte_cache_fifo #(
  parameter int DEPTH  = 16,
  parameter int ATOM_W = 30,
  parameter int WSEL_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ATOM_W-1:0] push_atom_i,
  input  logic [WSEL_W-1:0] push_wsel_i,
  input  logic              push_install_i,
  input  logic              pop_i,
  input  logic              kill_all_i,
  input  logic              kill_one_i,
  input  logic [ATOM_W-1:0] kill_atom_i,
  output logic [ATOM_W-1:0] head_atom_o,
  output logic [WSEL_W-1:0] head_wsel_o,
  output logic              head_install_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ATOM_W-1:0] atom_a [DEPTH];
  logic [WSEL_W-1:0] wsel_a [DEPTH];
  logic [DEPTH-1:0]  inst_a;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic              inst_q;
    logic [ATOM_W-1:0] atom_q;
    logic [WSEL_W-1:0] wsel_q;
    logic              load;

    assign load = push_i && (wr_ptr_q == PTR_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) inst_q <= 1'b0;
      else if (load) inst_q <= push_install_i;
      else if (kill_all_i || (kill_one_i && atom_q == kill_atom_i)) inst_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (load) begin
        atom_q <= push_atom_i;
        wsel_q <= push_wsel_i;
      end
    end

    assign inst_a[s] = inst_q;
    assign atom_a[s] = atom_q;
    assign wsel_a[s] = wsel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_atom_o    = atom_a[rd_ptr_q];
  assign head_wsel_o    = wsel_a[rd_ptr_q];
  assign head_install_o = inst_a[rd_ptr_q];
  assign count_o        = cnt_q;
  assign empty_o        = (cnt_q == '0);
  assign full_o         = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> cnt_q < CNT_W'(DEPTH));
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/pte_cache.sv
module pte_cache
  import pte_cache_pkg::*;
#(
  parameter int PA_W       = 34,
  parameter int ATOM_BYTES = 16,
  parameter int LINES      = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int OFF_W  = $clog2(ATOM_BYTES),
  localparam int ATOM_W = PA_W - OFF_W,
  localparam int DATA_W = ATOM_BYTES * 8,
  localparam int WSEL_W = $clog2(ATOM_BYTES / 4),
  localparam int IDX_W  = $clog2(LINES),
  localparam int HI_W   = PA_W - 32,
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              flush_hi_we_i,
  input  logic [31:0]       flush_hi_wdata_i,
  input  logic              flush_we_i,
  input  logic [31:0]       flush_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PA_W-1:0]   req_addr_i,
  output logic              resp_valid_o,
  output logic [31:0]       resp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  cfg_t             cfg_q;
  logic [HI_W-1:0]  flush_hi_q;
  logic             resp_valid_q;
  logic [31:0]      resp_data_q;

  logic [ATOM_W-1:0] req_atom, flush_atom, head_atom;
  logic [WSEL_W-1:0] req_wsel, head_wsel;
  logic [IDX_W-1:0]  req_idx, flush_idx, head_idx;
  logic              flush_all, flush_one, head_kill, head_install;
  logic              lookup_hit, hit, cap_reached, hit_acc, push, pop, store_wr;
  logic [DATA_W-1:0] lookup_data;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_empty, fifo_full;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata_i[31:30], cfg_wdata_i[28], cfg_wdata_i[23:6],
                         flush_wdata_i[OFF_W-1:1], flush_hi_wdata_i[31:HI_W],
                         req_addr_i[1:0]};

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= CFG_RESET;
      flush_hi_q <= '0;
    end else begin
      if (cfg_we_i) begin
        cfg_q.en    <= cfg_wdata_i[CFG_EN_BIT];
        cfg_q.limit <= cfg_wdata_i[CFG_LIM_LSB +: LIM_W];
        cfg_q.map   <= cfg_wdata_i[MAP_W-1:0];
      end
      if (flush_hi_we_i) flush_hi_q <= flush_hi_wdata_i[HI_W-1:0];
    end
  end

  assign flush_all  = flush_we_i && (flush_kind_e'(flush_wdata_i[0]) == FL_ALL);
  assign flush_one  = flush_we_i && (flush_kind_e'(flush_wdata_i[0]) == FL_ADDR);
  assign flush_atom = {flush_hi_q, flush_wdata_i[31:OFF_W]};

  assign req_atom = req_addr_i[PA_W-1:OFF_W];
  assign req_wsel = req_addr_i[OFF_W-1:2];

  pte_cache_index #(.IDX_W(IDX_W)) u_idx_req (
    .bits_i(req_atom[2*IDX_W-1:0]), .map_i(cfg_q.map), .idx_o(req_idx));
  pte_cache_index #(.IDX_W(IDX_W)) u_idx_flush (
    .bits_i(flush_atom[2*IDX_W-1:0]), .map_i(cfg_q.map), .idx_o(flush_idx));
  pte_cache_index #(.IDX_W(IDX_W)) u_idx_head (
    .bits_i(head_atom[2*IDX_W-1:0]), .map_i(cfg_q.map), .idx_o(head_idx));

  // a flush in the fill cycle also blocks that fill
  assign head_kill = flush_all || (flush_one && head_atom == flush_atom);
  assign pop       = mem_rsp_valid_i;
  assign store_wr  = pop && head_install && !head_kill;

  pte_cache_store #(.LINES(LINES), .ATOM_W(ATOM_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(req_idx), .rd_atom_i(req_atom),
    .rd_hit_o(lookup_hit), .rd_data_o(lookup_data),
    .wr_en_i(store_wr), .wr_idx_i(head_idx), .wr_atom_i(head_atom),
    .wr_data_i(mem_rsp_data_i),
    .inv_all_i(flush_all), .inv_one_i(flush_one),
    .inv_idx_i(flush_idx), .inv_atom_i(flush_atom));

  assign hit         = cfg_q.en && lookup_hit;
  assign cap_reached = (cfg_q.limit == '0) ? fifo_full
                                           : (fifo_count >= CNT_W'(cfg_q.limit));
  assign hit_acc     = req_valid_i && hit && fifo_empty;
  assign push        = req_valid_i && !hit && !cap_reached && mem_req_ready_i;

  assign req_ready_o     = hit ? fifo_empty : (!cap_reached && mem_req_ready_i);
  assign mem_req_valid_o = req_valid_i && !hit && !cap_reached;
  assign mem_req_addr_o  = {req_atom, {OFF_W{1'b0}}};

  pte_cache_fifo #(.DEPTH(FIFO_DEPTH), .ATOM_W(ATOM_W), .WSEL_W(WSEL_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_atom_i(req_atom), .push_wsel_i(req_wsel),
    .push_install_i(cfg_q.en),
    .pop_i(pop),
    .kill_all_i(flush_all), .kill_one_i(flush_one), .kill_atom_i(flush_atom),
    .head_atom_o(head_atom), .head_wsel_o(head_wsel), .head_install_o(head_install),
    .count_o(fifo_count), .empty_o(fifo_empty), .full_o(fifo_full));

  function automatic logic [31:0] pick(input logic [DATA_W-1:0] d,
                                       input logic [WSEL_W-1:0] s);
    return d[s*WORD_W +: WORD_W];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= hit_acc || pop;
      if (pop)          resp_data_q <= pick(mem_rsp_data_i, head_wsel);
      else if (hit_acc) resp_data_q <= pick(lookup_data, req_wsel);
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_data_o  = resp_data_q;

  assert_flush_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all |=> !lookup_hit);
  assert_fetch_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |->
      (cfg_q.limit == '0) || (fifo_count < CNT_W'(cfg_q.limit)));
  assert_hit_in_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && hit |-> fifo_empty && !mem_rsp_valid_i);
  assert_resp_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_acc && mem_rsp_valid_i));
endmodule

// File: tb/pte_cache_test.sv
module pte_cache_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_we_i = 1'b0, flush_hi_we_i = 1'b0, flush_we_i = 1'b0;
  logic [31:0]  cfg_wdata_i = '0, flush_hi_wdata_i = '0, flush_wdata_i = '0;
  logic         req_valid_i = 1'b0;
  logic [33:0]  req_addr_i = '0;
  logic         req_ready_o, resp_valid_o, mem_req_valid_o;
  logic [31:0]  resp_data_o;
  logic [33:0]  mem_req_addr_o;
  logic         mem_req_ready_i = 1'b1;
  logic         mem_rsp_valid_i = 1'b0;
  logic [127:0] mem_rsp_data_i = '0;

  pte_cache uut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0, fetch_cnt = 0;
  bit hold_rsp = 1'b0, done = 1'b0;
  logic [29:0] mq_atom[$];
  int          mq_time[$];
  logic [31:0] resp_q[$];

  function automatic logic [31:0] mem_word(input logic [29:0] a, input int w);
    return {a, 2'(w)} ^ 32'h5A3C_96E1;
  endfunction
  function automatic logic [127:0] atom_data(input logic [29:0] a);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = mem_word(a, k);
    return d;
  endfunction
  function automatic logic [33:0] addr_of(input logic [29:0] a, input int w);
    return {a, 2'(w), 2'b00};
  endfunction
  function automatic int idx_of(input logic [29:0] a, input logic [5:0] m);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (a[i] & m[i]) ^ (a[i+3] & m[i+3]);
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and response capture
  always @(posedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (mem_req_valid_o && mem_req_ready_i) begin
        mq_atom.push_back(mem_req_addr_o[33:4]);
        mq_time.push_back(cyc);
        fetch_cnt++;
      end
      if (!hold_rsp && mq_atom.size() > 0 && cyc - mq_time[0] >= 3) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= atom_data(mq_atom[0]);
        void'(mq_atom.pop_front());
        void'(mq_time.pop_front());
      end else begin
        mem_rsp_valid_i <= 1'b0;
      end
      if (resp_valid_o) resp_q.push_back(resp_data_o);
    end
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cfg_write(input bit en, input int lim, input logic [5:0] m);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = (32'(en) << 29) | (32'(lim & 15) << 24) | 32'(m);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask
  task automatic flush(input logic [31:0] v);
    @(negedge clk_i);
    flush_we_i = 1'b1; flush_wdata_i = v;
    @(negedge clk_i);
    flush_we_i = 1'b0;
  endtask
  task automatic hi_write(input logic [31:0] v);
    @(negedge clk_i);
    flush_hi_we_i = 1'b1; flush_hi_wdata_i = v;
    @(negedge clk_i);
    flush_hi_we_i = 1'b0;
  endtask
  task automatic try_req(input logic [33:0] a, output bit ok);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; ok = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (req_ready_o) begin ok = 1'b1; break; end
      @(negedge clk_i);
    end
    if (ok) begin @(posedge clk_i); #1; end
    req_valid_i = 1'b0;
  endtask
  task automatic wait_resp(input int n);
    while (resp_q.size() < n) @(negedge clk_i);
  endtask
  task automatic seq_req(input logic [29:0] a, input int w, input int exp_f, input string req);
    int n0, f0;
    bit ok;
    n0 = resp_q.size(); f0 = fetch_cnt;
    try_req(addr_of(a, w), ok);
    chk(ok, req, ok, 1);
    if (ok) begin
      wait_resp(n0 + 1);
      chk(resp_q[n0] == mem_word(a, w), req, resp_q[n0], mem_word(a, w));
      chk(fetch_cnt - f0 == exp_f, req, fetch_cnt - f0, exp_f);
    end
  endtask
  task automatic drain(input int n0, input logic [29:0] base, input int n, input string req);
    wait_resp(n0 + n);
    for (int i = 0; i < n; i++)
      chk(resp_q[n0+i] == mem_word(base + 30'(i), 0), req, resp_q[n0+i], mem_word(base + 30'(i), 0));
  endtask

  initial begin
    bit ok;
    int n0;
    bit mvalid[8];
    logic [29:0] mtag[8];
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
    chk(resp_valid_o == 1'b0, "R1 resp", resp_valid_o, 0);
    chk(mem_req_valid_o == 1'b0, "R1 memreq", mem_req_valid_o, 0);

    // R1/R2: disabled by default, every access fetches
    seq_req(30'h5, 0, 1, "R1 bypass");
    seq_req(30'h5, 1, 1, "R2 bypass");
    // R1/R6: default limit 8
    hold_rsp = 1'b1; n0 = resp_q.size();
    for (int i = 0; i < 8; i++) begin
      try_req(addr_of(30'h100 + 30'(i), 0), ok);
      chk(ok, "R1 limit accept", ok, 1);
    end
    try_req(addr_of(30'h108, 0), ok);
    chk(!ok, "R1 limit stall", ok, 0);
    hold_rsp = 1'b0;
    drain(n0, 30'h100, 8, "R5 order");

    // R3/R4
    cfg_write(1'b1, 8, 6'h3f);
    seq_req(30'h7, 2, 1, "R3 miss");
    seq_req(30'h7, 3, 0, "R4 hit");

    // R7 index mask
    flush(32'h0); cfg_write(1'b1, 8, 6'h00);
    seq_req(30'h11, 0, 1, "R7 m0"); seq_req(30'h22, 0, 1, "R7 m0");
    seq_req(30'h11, 0, 1, "R7 m0 evict");
    flush(32'h0); cfg_write(1'b1, 8, 6'h07);
    seq_req(30'h1, 0, 1, "R7 m7"); seq_req(30'h9, 0, 1, "R7 m7");
    seq_req(30'h1, 0, 1, "R7 m7 evict");
    flush(32'h0); cfg_write(1'b1, 8, 6'h3f);
    seq_req(30'h1, 0, 1, "R7 m3f"); seq_req(30'h9, 0, 1, "R7 m3f");
    seq_req(30'h1, 0, 0, "R7 m3f keep");

    // R8
    seq_req(30'h30, 0, 1, "R8 load"); seq_req(30'h31, 0, 1, "R8 load");
    flush(32'h0);
    seq_req(30'h30, 0, 1, "R8 gone"); seq_req(30'h31, 0, 1, "R8 gone");

    // R9 by address, low bits ignored
    seq_req(30'h41, 0, 1, "R9 load"); seq_req(30'h42, 0, 1, "R9 load");
    flush((32'h41 << 4) | 32'hF);
    seq_req(30'h41, 0, 1, "R9 flushed"); seq_req(30'h42, 0, 0, "R9 kept");

    // R10 high register
    hi_write(32'hFFFF_FFFE);
    seq_req(30'h2000_0004, 0, 1, "R10 load"); seq_req(30'h1000_0005, 0, 1, "R10 load");
    flush(32'h41); flush(32'h51);
    seq_req(30'h2000_0004, 1, 1, "R10 flushed"); seq_req(30'h1000_0005, 1, 0, "R10 kept");
    hi_write(32'h0);

    // R5/R6 limit 3 with hit under outstanding
    cfg_write(1'b1, 3, 6'h3f);
    seq_req(30'h60, 0, 1, "R5 preload");
    hold_rsp = 1'b1; n0 = resp_q.size();
    try_req(addr_of(30'h61, 0), ok); chk(ok, "R6 accept", ok, 1);
    try_req(addr_of(30'h60, 0), ok); chk(!ok, "R5 hit stalls", ok, 0);
    try_req(addr_of(30'h62, 0), ok); chk(ok, "R6 accept", ok, 1);
    try_req(addr_of(30'h63, 0), ok); chk(ok, "R6 accept", ok, 1);
    try_req(addr_of(30'h64, 0), ok); chk(!ok, "R6 stall", ok, 0);
    hold_rsp = 1'b0;
    drain(n0, 30'h61, 3, "R5 order");
    seq_req(30'h60, 1, 0, "R5 hit after drain");
    seq_req(30'h61, 1, 0, "R3 installed");

    // R11 flush while fill outstanding
    cfg_write(1'b1, 8, 6'h3f);
    hold_rsp = 1'b1; n0 = resp_q.size();
    try_req(addr_of(30'h70, 2), ok); chk(ok, "R11 accept", ok, 1);
    flush(32'h0);
    hold_rsp = 1'b0;
    wait_resp(n0 + 1);
    chk(resp_q[n0] == mem_word(30'h70, 2), "R11 data", resp_q[n0], mem_word(30'h70, 2));
    seq_req(30'h70, 0, 1, "R11 not installed");
    hold_rsp = 1'b1; n0 = resp_q.size();
    try_req(addr_of(30'h71, 0), ok); try_req(addr_of(30'h72, 0), ok);
    flush((32'h71 << 4) | 32'h1);
    hold_rsp = 1'b0;
    drain(n0, 30'h71, 2, "R11 order");
    seq_req(30'h71, 0, 1, "R11 addr flushed fill");
    seq_req(30'h72, 0, 0, "R11 other fill kept");

    // R12 disable keeps lines
    cfg_write(1'b0, 8, 6'h3f);
    seq_req(30'h72, 1, 1, "R12 disabled");
    cfg_write(1'b1, 8, 6'h3f);
    seq_req(30'h72, 2, 0, "R12 reenabled");

    // R6 limit 0 means 16
    cfg_write(1'b1, 0, 6'h3f);
    hold_rsp = 1'b1; n0 = resp_q.size();
    for (int i = 0; i < 16; i++) begin
      try_req(addr_of(30'h200 + 30'(i), 0), ok);
      chk(ok, "R6 zero accept", ok, 1);
    end
    try_req(addr_of(30'h210, 0), ok);
    chk(!ok, "R6 zero stall", ok, 0);
    hold_rsp = 1'b0;
    drain(n0, 30'h200, 16, "R6 zero order");

    // random phase with line model
    cfg_write(1'b1, 8, 6'h3f); flush(32'h0);
    for (int l = 0; l < 8; l++) mvalid[l] = 1'b0;
    for (int it = 0; it < 400; it++) begin
      int r, ix, w;
      logic [29:0] a;
      r = int'($urandom % 10);
      a = 30'h300 + 30'($urandom % 24);
      w = int'($urandom % 4);
      ix = idx_of(a, 6'h3f);
      if (r < 8) begin
        seq_req(a, w, (mvalid[ix] && mtag[ix] == a) ? 0 : 1, "R7 random");
        mvalid[ix] = 1'b1; mtag[ix] = a;
      end else if (r == 8) begin
        flush(32'h0);
        for (int l = 0; l < 8; l++) mvalid[l] = 1'b0;
      end else begin
        flush({a[27:0], 3'($urandom), 1'b1});
        if (mtag[ix] == a) mvalid[ix] = 1'b0;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule